// File: doc/BRIEF.md
# Clock Phase Enable Generator

This block turns one fast master clock into the full set of timing strobes a small computer system needs, so that every consumer runs on the same clock and reacts only when its enable is high. A free-running counter splits each slow system cycle into sixteen equal master-clock phases. Fixed phase values are decoded into single-cycle enable pulses: two for the processor (one for each half of its cycle), two for the video controller, one pixel enable, and one strobe for each memory access slot.

The pixel enable follows a mode input. In wide mode (640-pixel lines) it runs at half the master rate. In narrow mode (320-pixel lines) it runs at a quarter of the master rate. The counter and every enable are registered on the rising master-clock edge, which is the edge all consumers sample. Each enable is decoded from the next phase value, so the strobes leave flip-flops directly and add no decode logic in front of the consumers' enable pins.

The block has two named conditions. It is in RESET while `rst` is high. It enters RUN on the first edge with `rst` low, and it stays in RUN until `rst` rises again. In RUN the phase advances by one on each edge and wraps from 15 to 0.

Top module: `clkph_gen`

## Requirements
- R1: While `rst` is sampled high, the next edge sets `phase` to 0 and drives every enable and every `mem_slot` bit low.
- R2: When `rst` is low at an edge, `phase` advances by one at that edge and wraps from 15 to 0.
- R3: `cpu_en1` is high exactly in the cycles where `phase` is 0, and `cpu_en2` exactly where `phase` is 8. The exception is the phase-0 cycle that directly follows reset, where both stay low.
- R4: `vid_en1` is high exactly where `phase` is 4, and `vid_en2` exactly where `phase` is 12. The same exception after reset applies.
- R5: At most one of `cpu_en1`, `cpu_en2`, `vid_en1` and `vid_en2` is high in any cycle, and each is high for exactly one cycle per 16-phase system cycle.
- R6: With `hires` = 1 (wide mode), `pix_en` is high on every even phase, which gives 8 pulses per system cycle.
- R7: With `hires` = 0 (narrow mode), `pix_en` is high on phases 0, 4, 8 and 12 only. The value of `pix_en` in a cycle reflects `hires` as sampled on the edge that started that cycle.
- R8: `mem_slot[k]` is high exactly where `phase` equals 2·k, for k = 0..7. No slot bit is high on an odd phase, and `mem_slot` is never high on more than one bit at a time.
- R9: A reset applied mid-cycle restarts the sequence: `phase` is 0 in the cycle after the reset edge, and the normal pattern resumes from phase 1 once `rst` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, all logic on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hires | input | 1 | Pixel mode: 1 = 640-wide, 0 = 320-wide |
| phase | output | 4 | Current phase within the system cycle |
| cpu_en1 | output | 1 | Processor first-half enable |
| cpu_en2 | output | 1 | Processor second-half enable |
| vid_en1 | output | 1 | Video controller first enable |
| vid_en2 | output | 1 | Video controller second enable |
| pix_en | output | 1 | Pixel enable |
| mem_slot | output | 8 | One strobe per memory access slot |

## Verification
The bench runs long stretches with `hires` held at 1 and then at 0. Comparing the two pulse patterns shows whether the two pixel rates are wired to the right mode. It also toggles `hires` at odd and even phases, which shows whether the mode is sampled with the expected single-edge latency. It holds reset for several cycles and also releases it mid-cycle at phase 7, which separates a true counter restart from a phase that only masks the enables, and exposes the suppressed phase-0 strobes that follow reset.

// File: rtl/clkph_pkg.sv
package clkph_pkg;

    // Named condition of the generator
    typedef enum logic {
        GEN_RESET = 1'b0,
        GEN_RUN   = 1'b1
    } gen_state_e;

    // Fixed single-bit strobes produced each system cycle
    typedef struct packed {
        logic cpu1;
        logic cpu2;
        logic vid1;
        logic vid2;
        logic pix;
    } strobe_t;

endpackage

// File: rtl/clkph_counter.sv
module clkph_counter #(
    parameter int PHASES = 16,
    localparam int PW = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] phase_q,
    output logic [PW-1:0] phase_nxt,
    output logic          running
);
    import clkph_pkg::*;

    gen_state_e state_q;
    gen_state_e state_d;

    // next-state and next-phase logic
    always_comb begin
        state_d   = GEN_RUN;
        phase_nxt = '0;
        unique case (state_q)
            GEN_RESET: phase_nxt = PW'(1);
            GEN_RUN:   phase_nxt = (phase_q == PW'(PHASES - 1)) ? '0 : phase_q + 1'b1;
            default:   phase_nxt = '0;
        endcase
        if (rst) begin
            state_d   = GEN_RESET;
            phase_nxt = '0;
        end
    end

    // state and phase register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GEN_RESET;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_nxt;
        end
    end

    assign running = (state_q == GEN_RUN);

endmodule

// File: rtl/clkph_decode.sv
module clkph_decode #(
    parameter int PHASES    = 16,
    parameter int CPU1_PH   = 0,
    parameter int CPU2_PH   = 8,
    parameter int VID1_PH   = 4,
    parameter int VID2_PH   = 12,
    parameter int WIDE_DIV  = 2,
    parameter int NARROW_DIV = 4,
    parameter int MEM_SLOTS = 8,
    localparam int PW       = $clog2(PHASES),
    localparam int SLOT_LEN = PHASES / MEM_SLOTS
) (
    input  logic [PW-1:0]          phase_in,
    input  logic                   hires,
    output clkph_pkg::strobe_t     strobes,
    output logic [MEM_SLOTS-1:0]   slots
);
    int ph_int;

    always_comb begin
        ph_int       = int'(phase_in);
        strobes.cpu1 = (ph_int == CPU1_PH);
        strobes.cpu2 = (ph_int == CPU2_PH);
        strobes.vid1 = (ph_int == VID1_PH);
        strobes.vid2 = (ph_int == VID2_PH);
        strobes.pix  = hires ? ((ph_int % WIDE_DIV) == 0)
                             : ((ph_int % NARROW_DIV) == 0);
    end

    for (genvar k = 0; k < MEM_SLOTS; k++) begin : g_slot
        assign slots[k] = (phase_in == PW'(k * SLOT_LEN));
    end

endmodule

// File: rtl/clkph_gen.sv
module clkph_gen #(
    parameter int PHASES     = 16,
    parameter int CPU1_PH    = 0,
    parameter int CPU2_PH    = 8,
    parameter int VID1_PH    = 4,
    parameter int VID2_PH    = 12,
    parameter int WIDE_DIV   = 2,
    parameter int NARROW_DIV = 4,
    parameter int MEM_SLOTS  = 8,
    localparam int PW        = $clog2(PHASES),
    localparam int SLOT_LEN  = PHASES / MEM_SLOTS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hires,
    output logic [PW-1:0]        phase,
    output logic                 cpu_en1,
    output logic                 cpu_en2,
    output logic                 vid_en1,
    output logic                 vid_en2,
    output logic                 pix_en,
    output logic [MEM_SLOTS-1:0] mem_slot
);
    import clkph_pkg::*;

    logic [PW-1:0]        phase_nxt;
    logic                 running;
    strobe_t              strobe_d;
    strobe_t              strobe_q;
    logic [MEM_SLOTS-1:0] slot_d;
    logic [MEM_SLOTS-1:0] slot_q;

    clkph_counter #(.PHASES(PHASES)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .phase_q   (phase),
        .phase_nxt (phase_nxt),
        .running   (running)
    );

    // decode one phase ahead so the outputs are plain flops
    clkph_decode #(
        .PHASES     (PHASES),
        .CPU1_PH    (CPU1_PH),
        .CPU2_PH    (CPU2_PH),
        .VID1_PH    (VID1_PH),
        .VID2_PH    (VID2_PH),
        .WIDE_DIV   (WIDE_DIV),
        .NARROW_DIV (NARROW_DIV),
        .MEM_SLOTS  (MEM_SLOTS)
    ) u_dec (
        .phase_in (phase_nxt),
        .hires    (hires),
        .strobes  (strobe_d),
        .slots    (slot_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= '0;
            slot_q   <= '0;
        end else begin
            strobe_q <= strobe_d;
            slot_q   <= slot_d;
        end
    end

    always_comb begin
        cpu_en1  = strobe_q.cpu1;
        cpu_en2  = strobe_q.cpu2;
        vid_en1  = strobe_q.vid1;
        vid_en2  = strobe_q.vid2;
        pix_en   = strobe_q.pix;
        mem_slot = slot_q;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (phase == '0 && !cpu_en1 && !cpu_en2 && !vid_en1 && !vid_en2
                 && !pix_en && mem_slot == '0));

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PW'(PHASES - 1)) |=> (phase == $past(phase) + 1'b1));

    // R2
    phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PW'(PHASES - 1)) |=> (phase == '0));

    // R3
    cpu1_place_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_en1 |-> (phase == PW'(CPU1_PH) && running));

    // R3
    cpu2_place_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PW'(CPU2_PH) && !$past(rst)) |-> cpu_en2);

    // R4
    vid1_place_chk: assert property (@(posedge clk) disable iff (rst)
        vid_en1 |-> (phase == PW'(VID1_PH)));

    // R4
    vid2_place_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PW'(VID2_PH) && !$past(rst)) |-> vid_en2);

    // R5
    enable_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cpu_en1, cpu_en2, vid_en1, vid_en2}));

    // R7
    pix_narrow_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_en && !$past(hires)) |-> (phase[1:0] == 2'b00));

    // R8
    slot_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mem_slot));

    // R8
    slot_odd_chk: assert property (@(posedge clk) disable iff (rst)
        phase[0] |-> (mem_slot == '0));

endmodule

// File: tb/tb_clkph_gen.sv
module tb_clkph_gen;

    logic       clk = 1'b0;
    logic       rst;
    logic       hires;
    logic [3:0] phase;
    logic       cpu_en1, cpu_en2, vid_en1, vid_en2, pix_en;
    logic [7:0] mem_slot;

    int vectors  = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    // reference model state, updated at each rising edge
    int m_phase     = 0;
    bit m_fresh     = 1'b1;
    bit m_hires     = 1'b0;
    bit m_started   = 1'b0;

    always #2.5 clk = ~clk;

    clkph_gen dut (
        .clk      (clk),
        .rst      (rst),
        .hires    (hires),
        .phase    (phase),
        .cpu_en1  (cpu_en1),
        .cpu_en2  (cpu_en2),
        .vid_en1  (vid_en1),
        .vid_en2  (vid_en2),
        .pix_en   (pix_en),
        .mem_slot (mem_slot)
    );

    always @(posedge clk) begin
        cycles++;
        m_started = 1'b1;
        m_hires   = hires;
        if (rst) begin
            m_phase = 0;
            m_fresh = 1'b1;
        end else begin
            m_phase = m_fresh ? 1 : (m_phase + 1) % 16;
            m_fresh = 1'b0;
        end
    end

    task automatic cmp1(input string req, input string nm, input logic act, input logic exp);
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s at cycle %0d: got %0b expected %0b", req, nm, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (m_started && !done) begin
            logic [7:0] exp_slot;
            bit live;
            bit exp_pix;
            live = !m_fresh;
            exp_slot = '0;
            for (int k = 0; k < 8; k++)
                if (live && m_phase == 2 * k) exp_slot[k] = 1'b1;
            exp_pix = live && (m_hires ? (m_phase % 2 == 0) : (m_phase % 4 == 0));
            vectors++;
            if (phase !== 4'(m_phase)) begin
                failures++;
                $display("FAIL R2/R9 phase at cycle %0d: got %0d expected %0d", cycles, phase, m_phase);
            end
            cmp1("R3", "cpu_en1", cpu_en1, live && m_phase == 0);
            cmp1("R3", "cpu_en2", cpu_en2, live && m_phase == 8);
            cmp1("R4", "vid_en1", vid_en1, live && m_phase == 4);
            cmp1("R4", "vid_en2", vid_en2, live && m_phase == 12);
            cmp1(m_hires ? "R6" : "R7", "pix_en", pix_en, exp_pix);
            if (mem_slot !== exp_slot) begin
                failures++;
                $display("FAIL R8 mem_slot at cycle %0d: got %b expected %b", cycles, mem_slot, exp_slot);
            end
            if (m_fresh && (cpu_en1 | cpu_en2 | vid_en1 | vid_en2 | pix_en | (|mem_slot))) begin
                failures++;
                $display("FAIL R1 enables during reset at cycle %0d: got active expected all low", cycles);
            end
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst   = 1'b1;
        hires = 1'b1;
        wait_cycles(3);                 // R1 reset state held
        rst = 1'b0;
        wait_cycles(48);                // R6 wide mode, three system cycles
        hires = 1'b0;
        wait_cycles(48);                // R7 narrow mode
        wait_cycles(3);  hires = 1'b1;  // R7 toggle at odd phase
        wait_cycles(2);  hires = 1'b0;
        wait_cycles(5);  hires = 1'b1;
        wait_cycles(20);
        while (phase != 4'd7) @(negedge clk);
        rst = 1'b1;                     // R9 mid-cycle reset
        wait_cycles(1);
        rst = 1'b0;
        wait_cycles(40);
        rst = 1'b1;                     // R1 long reset
        wait_cycles(5);
        rst = 1'b0; hires = 1'b0;
        wait_cycles(40);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
        $finish;
    end

    initial begin
        #20000;
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
        $finish;
    end

endmodule